// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block drives an active-low system reset for a processor. It holds reset through power-up and for as long as the supply comparator reports that the supply is below its trip point. After the supply recovers, reset stays asserted for a fixed hold period, counted in ticks of a slow timebase. It also acts as a bus-activity watchdog: each START condition on a two-wire bus (SDA falling while SCL is high) restarts a tick counter. If the counter reaches the selected interval first, reset is asserted for the same full hold period.

The interval is chosen by a two-bit code that is captured into a register on a load strobe. The power-up reset does not clear that register, so the chosen interval survives a power cycle. A two-bit cause output records what produced the most recent reset, and a read strobe clears it.

The controller is a three-state machine:
- `ST_LOW`: supply bad, reset asserted.
- `ST_HOLD`: supply good, hold period running, reset asserted.
- `ST_RUN`: reset released, watchdog counting.

Its transitions are:
- LOW→HOLD when the supply flag goes true.
- HOLD→LOW and RUN→LOW when the supply flag goes false.
- HOLD→RUN when the last hold tick arrives.
- RUN→HOLD when the watchdog expires.
- The power-up reset forces LOW.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `por_n` is low, `rst_n` is 0 and `cause` is 2'b01 (power-up); the state machine is in ST_LOW.
- R2: When `vcc_ok` is 0 on a clock edge, `rst_n` is 0 after that edge. Leaving HOLD or RUN for this reason sets `cause` to 2'b10 (low supply).
- R3: After `vcc_ok` becomes 1, `rst_n` stays 0 for HOLD_TICKS pulses of `tick` and rises on the edge that takes the last of them.
- R4: A START (synchronized SDA falling while synchronized SCL is high in both the previous and the current sample) clears the watchdog counter. An SDA fall while SCL is low does not.
- R5: In RUN with the watchdog active, the limit-th `tick` since the last START (or since entering RUN) asserts reset, sets `cause` to 2'b11 (watchdog), and starts a full hold period.
- R6: The watchdog never expires while `wd_en` is 0 or the stored interval code is 2'b11.
- R7: The interval register loads `wd_sel` only on `wd_sel_ld`. `por_n` does not clear it. A load also clears the watchdog counter.
- R8: Interval codes map as follows: 2'b00 gives WD_T0 ticks, 2'b01 gives WD_T1 ticks, and 2'b10 gives WD_T2 ticks.
- R9: A `stat_rd` pulse clears `cause` to 2'b00. A new reset event in the same cycle takes precedence.
- R10: The watchdog counter is held at zero while reset is asserted, so every RUN period starts a fresh interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| tick | input | 1 | Timebase pulse, one clock wide |
| vcc_ok | input | 1 | Supply above trip point |
| sda | input | 1 | Bus data line (input sample) |
| scl | input | 1 | Bus clock line (input sample) |
| wd_en | input | 1 | Watchdog enable |
| wd_sel | input | 2 | Interval code to store |
| wd_sel_ld | input | 1 | Store strobe for `wd_sel` |
| stat_rd | input | 1 | Clears the cause status |
| rst_n | output | 1 | System reset, active low |
| cause | output | 2 | Last reset source: 00 none, 01 power-up, 10 low supply, 11 watchdog |

## Verification
- **Supply and tick changes:** `rst_n` and `cause` change on the first clock edge after a supply change or a deciding tick. This is because the state and the cause are registered and `rst_n` decodes the state.
- **START conditions:** a START takes three edges to clear the counter: two synchronizer stages, then the counter register.
- **Sampling:** the bench samples on a falling clock edge at least three clocks after each stimulus, so every result is already settled.
- **Tick counting:** each tick is a single pulse followed by idle clocks, so the expected tick counts in the table are exact and carry no margin.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } sup_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_POR  = 2'b01,
        CAUSE_LOW  = 2'b10,
        CAUSE_WDOG = 2'b11
    } sup_cause_e;

    localparam logic [1:0] SEL_OFF = 2'b11;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], din[b]};
            end
            assign dout[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sup_start_det.sv
module sup_start_det (
    input  logic clk,
    input  logic por_n,
    input  logic sda_s,
    input  logic scl_s,
    output logic start
);
    logic sda_q, scl_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sda_q <= 1'b1;
            scl_q <= 1'b1;
        end else begin
            sda_q <= sda_s;
            scl_q <= scl_s;
        end
    end

    assign start = sda_q & ~sda_s & scl_q & scl_s;

    assert_start_needs_scl_R4: assert property (@(posedge clk) disable iff (!por_n)
        start |-> (scl_s && $past(scl_s)));
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int WD_T0 = 3,
    parameter int WD_T1 = 6,
    parameter int WD_T2 = 9
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       tick,
    input  logic       run,
    input  logic       wd_en,
    input  logic [1:0] wd_sel,
    input  logic       wd_sel_ld,
    input  logic       start,
    output logic       expire
);
    import sup_pkg::*;

    localparam int TMAX = (WD_T2 > WD_T1) ? ((WD_T2 > WD_T0) ? WD_T2 : WD_T0)
                                          : ((WD_T1 > WD_T0) ? WD_T1 : WD_T0);
    localparam int CW = $clog2(TMAX + 1);

    logic [1:0]    sel_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          active;

    // Retained across power-up reset: no reset branch (R7).
    always_ff @(posedge clk) begin
        if (wd_sel_ld) sel_q <= wd_sel;
    end

    always_comb begin
        unique case (sel_q)
            2'b00:   lim = CW'(WD_T0);
            2'b01:   lim = CW'(WD_T1);
            2'b10:   lim = CW'(WD_T2);
            default: lim = CW'(TMAX);
        endcase
    end

    assign active = wd_en && (sel_q != SEL_OFF);
    assign expire = active && run && tick && (cnt == lim - CW'(1));

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                                 cnt <= '0;
        else if (!run || !active || start || wd_sel_ld) cnt <= '0;
        else if (expire)                            cnt <= '0;
        else if (tick)                              cnt <= cnt + CW'(1);
    end

    assert_kick_clears_R4: assert property (@(posedge clk) disable iff (!por_n)
        start |=> (cnt == '0));
    assert_cnt_in_window_R5: assert property (@(posedge clk) disable iff (!por_n)
        active |-> (cnt < lim));
    assert_off_never_fires_R6: assert property (@(posedge clk) disable iff (!por_n)
        !active |-> !expire);
    assert_idle_in_reset_R10: assert property (@(posedge clk) disable iff (!por_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
    parameter int HOLD_TICKS = 200,
    parameter int WD_T0      = 150,
    parameter int WD_T1      = 600,
    parameter int WD_T2      = 1200
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       tick,
    input  logic       vcc_ok,
    input  logic       sda,
    input  logic       scl,
    input  logic       wd_en,
    input  logic [1:0] wd_sel,
    input  logic       wd_sel_ld,
    input  logic       stat_rd,
    output logic       rst_n,
    output logic [1:0] cause
);
    import sup_pkg::*;

    localparam int HW = $clog2(HOLD_TICKS + 1);

    sup_state_e    state, state_nx;
    sup_cause_e    cause_q;
    logic [HW-1:0] hold_cnt;
    logic [1:0]    bus_s;
    logic          start, wd_expire, hold_done;

    sup_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .por_n(por_n), .din({scl, sda}), .dout(bus_s)
    );

    sup_start_det u_start (
        .clk(clk), .por_n(por_n), .sda_s(bus_s[0]), .scl_s(bus_s[1]), .start(start)
    );

    sup_wdog #(.WD_T0(WD_T0), .WD_T1(WD_T1), .WD_T2(WD_T2)) u_wdog (
        .clk(clk), .por_n(por_n), .tick(tick), .run(state == ST_RUN),
        .wd_en(wd_en), .wd_sel(wd_sel), .wd_sel_ld(wd_sel_ld),
        .start(start), .expire(wd_expire)
    );

    assign hold_done = tick && (hold_cnt == HW'(HOLD_TICKS - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOW:  if (vcc_ok) state_nx = ST_HOLD;
            ST_HOLD: if (!vcc_ok) state_nx = ST_LOW;
                     else if (hold_done) state_nx = ST_RUN;
            ST_RUN:  if (!vcc_ok) state_nx = ST_LOW;
                     else if (wd_expire) state_nx = ST_HOLD;
            default: state_nx = ST_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_LOW;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                  hold_cnt <= '0;
        else if (state != ST_HOLD)   hold_cnt <= '0;
        else if (tick)               hold_cnt <= hold_cnt + HW'(1);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_q <= CAUSE_POR;
        end else if (state != ST_LOW && !vcc_ok) begin
            cause_q <= CAUSE_LOW;
        end else if (state == ST_RUN && wd_expire) begin
            cause_q <= CAUSE_WDOG;
        end else if (stat_rd) begin
            cause_q <= CAUSE_NONE;
        end
    end

    assign rst_n = (state == ST_RUN);
    assign cause = cause_q;

    assert_low_supply_resets_R2: assert property (@(posedge clk) disable iff (!por_n)
        !vcc_ok |=> !rst_n);
    assert_release_after_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n) |-> ($past(tick) && $past(vcc_ok) && $past(hold_cnt) == HW'(HOLD_TICKS - 1)));
    assert_wdog_reset_cause_R5: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && vcc_ok && wd_expire) |=> (!rst_n && cause == CAUSE_WDOG));
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!por_n)
        (stat_rd && rst_n && vcc_ok && !wd_expire) |=> (cause == CAUSE_NONE));
endmodule

// File: tb/sup_reset_ctrl_tb.sv
module sup_reset_ctrl_tb;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic por_n = 1'b0, tick = 1'b0, vcc_ok = 1'b0, sda = 1'b1, scl = 1'b1;
    logic wd_en = 1'b0, wd_sel_ld = 1'b0, stat_rd = 1'b0;
    logic [1:0] wd_sel = 2'b01;
    logic rst_n;
    logic [1:0] cause;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sup_reset_ctrl #(.HOLD_TICKS(HOLD), .WD_T0(3), .WD_T1(6), .WD_T2(9)) u_dut (
        .clk(clk), .por_n(por_n), .tick(tick), .vcc_ok(vcc_ok), .sda(sda), .scl(scl),
        .wd_en(wd_en), .wd_sel(wd_sel), .wd_sel_ld(wd_sel_ld), .stat_rd(stat_rd),
        .rst_n(rst_n), .cause(cause)
    );

    typedef struct packed {
        logic       vcc;
        logic       en;
        logic       kick;
        logic       rd;
        logic [7:0] nt;
        logic       ex_rst;
        logic [1:0] ex_cause;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [0:NV-1] = '{
        vec_t'{1'b1, 1'b0, 1'b0, 1'b0, 8'd3,  1'b0, 2'b01, 4'd3},
        vec_t'{1'b1, 1'b0, 1'b0, 1'b0, 8'd1,  1'b1, 2'b01, 4'd3},
        vec_t'{1'b1, 1'b0, 1'b0, 1'b1, 8'd0,  1'b1, 2'b00, 4'd9},
        vec_t'{1'b1, 1'b0, 1'b0, 1'b0, 8'd20, 1'b1, 2'b00, 4'd6},
        vec_t'{1'b1, 1'b1, 1'b0, 1'b0, 8'd5,  1'b1, 2'b00, 4'd5},
        vec_t'{1'b1, 1'b1, 1'b1, 1'b0, 8'd5,  1'b1, 2'b00, 4'd4},
        vec_t'{1'b1, 1'b1, 1'b0, 1'b0, 8'd1,  1'b0, 2'b11, 4'd5},
        vec_t'{1'b1, 1'b1, 1'b0, 1'b0, 8'd3,  1'b0, 2'b11, 4'd5},
        vec_t'{1'b1, 1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 2'b11, 4'd10},
        vec_t'{1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  1'b0, 2'b10, 4'd2},
        vec_t'{1'b0, 1'b1, 1'b0, 1'b0, 8'd10, 1'b0, 2'b10, 4'd2},
        vec_t'{1'b1, 1'b1, 1'b0, 1'b0, 8'd3,  1'b0, 2'b10, 4'd3},
        vec_t'{1'b1, 1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 2'b10, 4'd3}
    };

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            clks(3);
        end
    endtask

    task automatic kick();
        @(negedge clk) sda = 1'b0;
        clks(5);
        sda = 1'b1;
        clks(5);
    endtask

    task automatic false_kick();
        @(negedge clk) scl = 1'b0;
        clks(3);
        sda = 1'b0;
        clks(3);
        scl = 1'b1;
        clks(3);
        sda = 1'b1;
        clks(3);
    endtask

    task automatic load_sel(input logic [1:0] s);
        @(negedge clk) begin
            wd_sel = s;
            wd_sel_ld = 1'b1;
        end
        @(negedge clk) wd_sel_ld = 1'b0;
        clks(2);
    endtask

    task automatic check(input string req, input logic ex_rst, input logic [1:0] ex_cause);
        checks++;
        if (rst_n !== ex_rst || cause !== ex_cause) begin
            errors++;
            $display("FAIL %s: rst_n=%b cause=%b expected rst_n=%b cause=%b",
                     req, rst_n, cause, ex_rst, ex_cause);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, rst_n=%b cause=%b expected completion", rst_n, cause);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        load_sel(2'b01);
        clks(2);
        check("R1", 1'b0, 2'b01);
        @(negedge clk) por_n = 1'b1;
        clks(2);
        check("R1", 1'b0, 2'b01);

        for (int v = 0; v < NV; v++) begin
            vcc_ok = VEC[v].vcc;
            wd_en = VEC[v].en;
            clks(3);
            if (VEC[v].kick) kick();
            if (VEC[v].rd) begin
                @(negedge clk) stat_rd = 1'b1;
                @(negedge clk) stat_rd = 1'b0;
            end
            ticks(int'(VEC[v].nt));
            clks(3);
            check($sformatf("R%0d row%0d", VEC[v].req, v), VEC[v].ex_rst, VEC[v].ex_cause);
        end

        // R7: stored interval (6) survives a power cycle; wd_sel changed but not loaded
        wd_sel = 2'b00;
        @(negedge clk) por_n = 1'b0;
        clks(3);
        check("R1 power cycle", 1'b0, 2'b01);
        @(negedge clk) por_n = 1'b1;
        clks(3);
        ticks(HOLD);
        clks(2);
        check("R3 after power cycle", 1'b1, 2'b01);
        ticks(5);
        check("R7 no expiry at 5", 1'b1, 2'b01);
        ticks(1);
        check("R7 expiry at 6", 1'b0, 2'b11);
        ticks(HOLD);
        clks(2);

        // R8: code 00 -> 3 ticks
        load_sel(2'b00);
        ticks(2);
        check("R8 code00 at 2", 1'b1, 2'b11);
        ticks(1);
        check("R8 code00 at 3", 1'b0, 2'b11);
        ticks(HOLD);
        clks(2);

        // R8: code 10 -> 9 ticks
        load_sel(2'b10);
        ticks(8);
        check("R8 code10 at 8", 1'b1, 2'b11);
        ticks(1);
        check("R8 code10 at 9", 1'b0, 2'b11);
        ticks(HOLD);
        clks(2);

        // R4: SDA fall while SCL low is not a START
        load_sel(2'b00);
        ticks(2);
        false_kick();
        ticks(1);
        check("R4 no kick when scl low", 1'b0, 2'b11);
        ticks(HOLD);
        clks(2);

        // R6: code 11 disables the watchdog
        load_sel(2'b11);
        ticks(20);
        check("R6 code11 off", 1'b1, 2'b11);

        // R9: read clears status
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
        clks(2);
        check("R9 clear", 1'b1, 2'b00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule